// File: doc/BRIEF.md
# Wakeup Pin Interrupt Flag Register

This block collects interrupt requests from six wakeup pins. Each pin has its own configuration. One input arms the pin as an interrupt source, and a second input chooses whether a rising or a falling transition counts as an event. Every pin passes through a synchronizer before edge detection. A detected edge on an armed pin latches a sticky request flag for that channel. A combined interrupt output is raised whenever any flag is set on a channel whose request enable is high.

Software reaches the flags through a plain synchronous register port made of a select, a write strobe, an 8-bit write bus and an 8-bit read bus. A read returns the six flags in the low bits, and the two top bits always read as one. A write clears every flag whose bit position carries a zero and leaves alone every flag whose bit carries a one. This lets one handler clear its own flag without disturbing the others. The port has no back-pressure: an access completes in the cycle it is presented, so it needs no valid/ready pair. All pin, configuration and enable inputs are plain level signals.

Top module: `wake_flag_reg`

## Requirements
- R1: After reset all six flags are 0, a selected read returns 8'hC0, and `irq_o` is 0.
- R2: Read bits 7 and 6 are always 1. Write data in bits 7 and 6 has no effect on any flag.
- R3: An edge on pin i that is selected for an armed channel sets flag i (read bit i). The flag is visible on a read after the third rising clock edge that follows the pin change, counting the two synchronizer stages and the edge-history register.
- R4: A write (`sel_i`=1 and `wr_i`=1) with bit i of `wdata_i` equal to 0 clears flag i at the next clock edge. When `sel_i` or `wr_i` is 0, no flag changes due to the write bus.
- R5: Writing 1 in bit i leaves flag i unchanged.
- R6: If an edge is detected on channel i in the same cycle as a clearing write to bit i, flag i is 1 afterwards.
- R7: While `arm_i[i]` is 0, edges on pin i are ignored and flag i keeps its value.
- R8: `rdata_o` equals {2'b11, flags} in the same cycle that `sel_i` is 1, and 8'h00 while `sel_i` is 0.
- R9: `irq_o` is the OR over channels of flag i AND `irq_en_i[i]`. It follows enable changes in the same cycle and stays high until the contributing flags are cleared.
- R10: `rise_sel_i[i]`=1 selects rising edges and 0 selects falling edges. The edge of the other polarity does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 6 | Asynchronous wakeup pins |
| arm_i | input | 6 | Per-pin: 1 = pin acts as interrupt input |
| rise_sel_i | input | 6 | Per-pin edge choice: 1 rising, 0 falling |
| irq_en_i | input | 6 | Per-channel request enable for `irq_o` |
| sel_i | input | 1 | Register select |
| wr_i | input | 1 | Write strobe, qualified by `sel_i` |
| wdata_i | input | 8 | Write data; 0 bits clear flags |
| rdata_o | output | 8 | Read data, valid while `sel_i` is high |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A flag that is stuck or lost shows up on the very next selected read. A missing interrupt shows up on `irq_o` in the same cycle. A synchronizer or edge-history stage that is too short or too long moves the flag by one cycle relative to the three-edge latency, so the bench samples exactly at that boundary. A wrong polarity, a clear mask applied to the wrong bits, or a collision resolved in favour of the clear leaves a flag value that differs from the expected one at the following read.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int unsigned NCHAN_DEF = 6;
  localparam int unsigned DW_DEF = 8;
  localparam int unsigned SYNC_DEF = 2;

  typedef enum logic { EDGE_FALL = 1'b0, EDGE_RISE = 1'b1 } edge_pol_e;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wake_chan.sv
module wake_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s_i,
  input  logic arm_i,
  input  wake_pkg::edge_pol_e pol_i,
  input  logic clr_i,
  output logic flag_o
);
  import wake_pkg::*;

  logic prev_q;
  logic hit;
  logic set_req;
  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pin_s_i;
  end

  always_comb begin
    unique case (pol_i)
      EDGE_RISE: hit = pin_s_i & ~prev_q;
      default:   hit = ~pin_s_i & prev_q;
    endcase
  end

  assign set_req = hit & arm_i;

  always_ff @(posedge clk) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_req) flag_q <= 1'b1;
    else if (clr_i)   flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R3: a flag only rises after an armed, selected edge
  assert_set_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(set_req));
  // R4: a clear with no competing set empties the flag
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_req) |=> !flag_q);
  // R5 / R7: with no set and no clear, the flag holds
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_req) |=> $stable(flag_q));
  // R6: set beats clear
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req && clr_i) |=> flag_q);
  // R7: disarmed pin never sets
  assert_disarmed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm_i && !flag_q) |=> !flag_q);
endmodule

// File: rtl/wake_rdfmt.sv
module wake_rdfmt #(
  parameter int unsigned NCHAN = 6,
  parameter int unsigned DW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  input  logic [NCHAN-1:0] flags_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned NRSV = DW - NCHAN;

  always_comb begin
    rdata_o = '0;
    if (sel_i) rdata_o = {{NRSV{1'b1}}, flags_i};
  end

  // R8 / R2: reserved bits read as ones while selected, bus idle otherwise
  assert_rsv_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_i |-> (rdata_o[DW-1:NCHAN] == {NRSV{1'b1}}));
  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |-> (rdata_o == '0));
endmodule

// File: rtl/wake_flag_reg.sv
module wake_flag_reg #(
  parameter int unsigned NCHAN = wake_pkg::NCHAN_DEF,
  parameter int unsigned DW = wake_pkg::DW_DEF,
  parameter int unsigned SYNC_STAGES = wake_pkg::SYNC_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [NCHAN-1:0] pin_i,
  input  logic [NCHAN-1:0] arm_i,
  input  logic [NCHAN-1:0] rise_sel_i,
  input  logic [NCHAN-1:0] irq_en_i,
  input  logic sel_i,
  input  logic wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic irq_o
);
  import wake_pkg::*;

  logic [NCHAN-1:0] pin_s;
  logic [NCHAN-1:0] flags;
  logic [NCHAN-1:0] clr;
  logic wr_hit;
  logic unused_rsv_wdata;

  assign wr_hit = sel_i & wr_i;
  assign unused_rsv_wdata = ^wdata_i[DW-1:NCHAN];

  for (genvar g = 0; g < NCHAN; g++) begin : g_ch
    edge_pol_e pol;
    assign pol = rise_sel_i[g] ? EDGE_RISE : EDGE_FALL;
    assign clr[g] = wr_hit & ~wdata_i[g];

    wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(pin_i[g]), .q_o(pin_s[g])
    );

    wake_chan u_chan (
      .clk(clk), .rst_n(rst_n), .pin_s_i(pin_s[g]), .arm_i(arm_i[g]),
      .pol_i(pol), .clr_i(clr[g]), .flag_o(flags[g])
    );
  end

  wake_rdfmt #(.NCHAN(NCHAN), .DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .flags_i(flags), .rdata_o(rdata_o)
  );

  assign irq_o = |(flags & irq_en_i);

  // R4: without a qualified write, no flag may fall
  assert_no_stray_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> ((flags & $past(flags)) == $past(flags)));
  // R9: request stays up while an enabled flag is held and enables are steady
  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !wr_hit) ##1 $stable(irq_en_i) |-> irq_o);
endmodule

// File: tb/wake_flag_reg_bench.sv
module wake_flag_reg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pin = '0, arm = '1, rise = '1, en = '1;
  logic sel = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq;
  int vecs = 0, errs = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_flag_reg u_wake_flag_reg (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .arm_i(arm), .rise_sel_i(rise),
    .irq_en_i(en), .sel_i(sel), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic rd(output logic [7:0] v);
    sel = 1'b1; wr = 1'b0;
    #1 v = rdata;
    sel = 1'b0;
  endtask

  task automatic wrb(input logic [7:0] d);
    sel = 1'b1; wr = 1'b1; wdata = d;
    cyc(1);
    sel = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(v);
    chk("R1", v, 8'hC0);
    chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_rise_latency;
    logic [7:0] v;
    pin[0] = 1'b1;
    cyc(2);
    rd(v); chk("R3 early", v, 8'hC0);
    cyc(1);
    rd(v); chk("R3", v, 8'hC1);
    chk("R9 irq", {7'd0, irq}, 8'h01);
    wrb(8'hFE);
    rd(v); chk("R4 clear", v, 8'hC0);
    chk("R9 irq drop", {7'd0, irq}, 8'h00);
    pin[0] = 1'b0; cyc(4);
  endtask

  task automatic t_falling;
    logic [7:0] v;
    rise[2] = 1'b0;
    pin[2] = 1'b1; cyc(4);
    rd(v); chk("R10 rise ignored", v, 8'hC0);
    pin[2] = 1'b0; cyc(3);
    rd(v); chk("R10 fall", v, 8'hC4);
    wrb(8'h00);
    rise[2] = 1'b1;
  endtask

  task automatic t_disarmed;
    logic [7:0] v;
    pin[3] = 1'b1; cyc(3);
    rd(v); chk("R3 ch3", v, 8'hC8);
    arm[3] = 1'b0;
    pin[3] = 1'b0; cyc(2); pin[3] = 1'b1; cyc(4);
    rd(v); chk("R7 keep", v, 8'hC8);
    wrb(8'hF7);
    pin[3] = 1'b0; cyc(2); pin[3] = 1'b1; cyc(4);
    rd(v); chk("R7 ignore", v, 8'hC0);
    pin[3] = 1'b0; cyc(4);
    arm[3] = 1'b1;
  endtask

  task automatic t_selective;
    logic [7:0] v;
    pin[1] = 1'b1; pin[4] = 1'b1; pin[5] = 1'b1; cyc(3);
    rd(v); chk("R3 multi", v, 8'hF2);
    sel = 1'b0; wr = 1'b1; wdata = 8'h00; cyc(1); wr = 1'b0;
    rd(v); chk("R4 unselected", v, 8'hF2);
    wrb(8'hEF);
    rd(v); chk("R4 one bit", v, 8'hE2);
    wrb(8'hFF);
    rd(v); chk("R5", v, 8'hE2);
    wrb(8'h3F);
    rd(v); chk("R2", v, 8'hE2);
    wrb(8'hC0);
    rd(v); chk("R4 all", v, 8'hC0);
    pin[1] = 1'b0; pin[4] = 1'b0; pin[5] = 1'b0; cyc(4);
  endtask

  task automatic t_collision;
    logic [7:0] v;
    pin[0] = 1'b1;
    cyc(2);
    sel = 1'b1; wr = 1'b1; wdata = 8'h00;
    cyc(1);
    sel = 1'b0; wr = 1'b0;
    rd(v); chk("R6", v, 8'hC1);
    wrb(8'h00);
    pin[0] = 1'b0; cyc(4);
  endtask

  task automatic t_irq_mask;
    logic [7:0] v;
    en = 6'b111110;
    pin[0] = 1'b1; cyc(3);
    chk("R9 masked", {7'd0, irq}, 8'h00);
    en[0] = 1'b1; #1;
    chk("R9 unmasked", {7'd0, irq}, 8'h01);
    cyc(3);
    chk("R9 held", {7'd0, irq}, 8'h01);
    #1 chk("R8 idle", rdata, 8'h00);
    wrb(8'h00);
    pin[0] = 1'b0; cyc(4);
    rd(v); chk("R8 sel", v, 8'hC0);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset;
    t_rise_latency;
    t_falling;
    t_disarmed;
    t_selective;
    t_collision;
    t_irq_mask;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    vecs++; errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule